// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This block takes a 64-bit source word and a 64-bit mask and performs one of two bit-scatter/gather operations, selected by a single operation bit. In extract mode it collects the source bits found at the mask's set positions and packs them, in order, into the low end of the result. In deposit mode it takes the lowest source bits in turn and places them at the mask's set positions. Both operations walk the mask from the least significant end. Every result bit that no step writes is zero.

The result is registered. A request presented with `in_valid` high appears one clock later with `out_valid` high. No flags or status are produced. Result ports are written `[63:0]` with index 0 as the least significant bit. In the MSB-first numbering, where position p is the bit of weight 2^(63-p), position p maps to port index 63-p.

A two-state output machine tracks whether the result register holds a fresh answer. `ST_IDLE` means no new result and `out_valid` is low. `ST_HOLD` means a new result was captured in the previous cycle and `out_valid` is high. The transitions are:

- Capture: `ST_IDLE`/`ST_HOLD` → `ST_HOLD`, taken when `in_valid` is 1.
- Drain: `ST_IDLE`/`ST_HOLD` → `ST_IDLE`, taken when `in_valid` is 0.
- Reset: any state → `ST_IDLE`.

Top module: `pbx_unit`

## Requirements
- R1: With `op_sel`=0 (extract), the j-th set mask bit counted from index 0 upward (j starting at 0) selects the source bit at that same index and places it at result index j.
- R2: In extract mode, every result bit at index ≥ popcount(mask) is 0.
- R3: With `op_sel`=1 (deposit), for each set mask bit at index m, the result bit at m equals source bit r, where r is the number of set mask bits below index m.
- R4: In deposit mode, every result bit at an index where the mask bit is 0 is 0.
- R5: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid`=1, and the result of that request is present on `out_result` then.
- R6: Synchronous active-high `rst` drives `out_valid` to 0 and `out_result` to all zeros at the next clock edge.
- R7: While `in_valid` is 0, `out_result` keeps its last value and `out_valid` is 0.
- R8: Depositing the extract result with the same mask returns source AND mask.
- R9: An all-ones mask returns the source unchanged in both modes. An all-zeros mask returns zero in both modes.
- R10: Back-to-back requests on consecutive cycles each produce their own result one cycle later, with `out_valid` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = extract, 1 = deposit |
| src_word | input | 64 | Source word |
| mask_word | input | 64 | Mask word |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Registered result |

## Verification
The patterns include:

- Full and empty masks. These separate a true gather/scatter from a pass-through or a zeroing path.
- Nibble-striped and alternating masks with all-ones, complementary and aligned sources. These show whether bit order and rank counting are right, and whether upper result bits are cleared.
- Masks with only the extreme bits set. These expose off-by-one rank errors at both ends of the word.
- Pseudo-random words compared against a loop model. Each extract result is also fed back through deposit, which tests that the two operations are inverses.
- Back-to-back requests and idle gaps. These separate the valid timing from the hold behaviour.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
    typedef enum logic {
        OP_EXTRACT = 1'b0,
        OP_DEPOSIT = 1'b1
    } pbx_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pbx_state_e;
endpackage

// File: rtl/pbx_rank.sv
module pbx_rank #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]         mask,
    output logic [W-1:0][CW-1:0] rank
);
    // rank[m] = number of set mask bits strictly below index m
    assign rank[0] = '0;
    for (genvar m = 1; m < W; m++) begin : g_rank
        assign rank[m] = rank[m-1] + CW'(mask[m-1]);
    end
endmodule

// File: rtl/pbx_extract.sv
module pbx_extract #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1),
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]         src,
    input  logic [W-1:0]         mask,
    input  logic [W-1:0][CW-1:0] rank,
    output logic [W-1:0]         res
);
    always_comb begin
        res = '0;
        for (int m = 0; m < W; m++) begin
            if (mask[m]) begin
                res[rank[m][IW-1:0]] = src[m];
            end
        end
    end
endmodule

// File: rtl/pbx_deposit.sv
module pbx_deposit #(
    parameter int W  = 64,
    parameter int CW = $clog2(W + 1),
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]         src,
    input  logic [W-1:0]         mask,
    input  logic [W-1:0][CW-1:0] rank,
    output logic [W-1:0]         res
);
    for (genvar m = 0; m < W; m++) begin : g_dep
        assign res[m] = mask[m] & src[rank[m][IW-1:0]];
    end
endmodule

// File: rtl/pbx_unit.sv
module pbx_unit #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         op_sel,
    input  logic [W-1:0] src_word,
    input  logic [W-1:0] mask_word,
    output logic         out_valid,
    output logic [W-1:0] out_result
);
    import pbx_pkg::*;

    localparam int CW = $clog2(W + 1);
    localparam int IW = $clog2(W);

    logic [W-1:0][CW-1:0] rank;
    logic [W-1:0]         ext_res;
    logic [W-1:0]         dep_res;
    logic [W-1:0]         next_res;
    pbx_op_e              op;
    pbx_state_e           state_q;
    pbx_state_e           state_d;

    assign op = pbx_op_e'(op_sel);

    pbx_rank #(.W(W), .CW(CW)) u_rank (
        .mask (mask_word),
        .rank (rank)
    );

    pbx_extract #(.W(W), .CW(CW), .IW(IW)) u_ext (
        .src  (src_word),
        .mask (mask_word),
        .rank (rank),
        .res  (ext_res)
    );

    pbx_deposit #(.W(W), .CW(CW), .IW(IW)) u_dep (
        .src  (src_word),
        .mask (mask_word),
        .rank (rank),
        .res  (dep_res)
    );

    always_comb begin
        unique case (op)
            OP_EXTRACT: next_res = ext_res;
            OP_DEPOSIT: next_res = dep_res;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = in_valid ? ST_HOLD : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_result <= '0;
        else if (in_valid) out_result <= next_res;
    end

    assign out_valid = (state_q == ST_HOLD);

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    // R5
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    ext_width_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel) |=>
            ($countones(out_result) <= $countones($past(mask_word))));
    // R4
    dep_outside_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel) |=> ((out_result & ~$past(mask_word)) == '0));
    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && !out_valid));
endmodule

// File: tb/sim_pbx_unit.sv
module sim_pbx_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    // {op, src, mask, expected}
    localparam logic [192:0] VEC [0:NV-1] = '{
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0000_0000_FFFF_FFFF},
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0F0F_0F0F_0F0F_0F0F},
        {1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF},
        {1'b1, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {1'b1, 64'h0000_0000_0000_00FF, 64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0000},
        {1'b0, 64'hAB00_0000_0000_0000, 64'hFF00_0000_0000_0000, 64'h0000_0000_0000_00AB},
        {1'b0, 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0000},
        {1'b1, 64'h0000_0000_FFFF_FFFF, 64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555},
        {1'b1, 64'h0000_0000_0000_0003, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001},
        {1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0002}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [63:0] src_word = '0;
    logic [63:0] mask_word = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_errors = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    pbx_unit #(.W(64)) u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .src_word   (src_word),
        .mask_word  (mask_word),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [63:0] ref_ext(logic [63:0] s, logic [63:0] m);
        logic [63:0] r = '0;
        int k = 0;
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                r[k] = s[i];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_dep(logic [63:0] s, logic [63:0] m);
        logic [63:0] r = '0;
        int k = 0;
        for (int i = 0; i < 64; i++) begin
            if (m[i]) begin
                r[i] = s[k];
                k++;
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] next_rng(logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, capture at the next rising edge, sample at the following falling edge
    task automatic issue(logic op, logic [63:0] s, logic [63:0] m);
        in_valid  = 1'b1;
        op_sel    = op;
        src_word  = s;
        mask_word = m;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] s, m, e, x;

        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 valid", {63'd0, out_valid}, 64'd0);
        check("R6 result", out_result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R9: table of vectors
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][192], VEC[i][191:128], VEC[i][127:64]);
            check("R5 valid", {63'd0, out_valid}, 64'd1);
            check(VEC[i][192] ? "R3 deposit vec" : "R1 extract vec", out_result, VEC[i][63:0]);
        end

        // R7: hold while idle
        @(negedge clk);
        check("R7 valid low", {63'd0, out_valid}, 64'd0);
        check("R7 hold", out_result, VEC[NV-1][63:0]);
        src_word  = 64'hDEAD_BEEF_DEAD_BEEF;
        mask_word = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check("R7 hold inputs moved", out_result, VEC[NV-1][63:0]);

        // R2 R4 R8: random words vs model and round trip
        for (int i = 0; i < 40; i++) begin
            rng = next_rng(rng); s = rng;
            rng = next_rng(rng); m = rng;
            if (i % 4 == 1) m = m & next_rng(rng);
            issue(1'b0, s, m);
            e = ref_ext(s, m);
            check("R1 R2 random extract", out_result, e);
            x = out_result;
            issue(1'b1, s, m);
            check("R3 R4 random deposit", out_result, ref_dep(s, m));
            issue(1'b1, x, m);
            check("R8 round trip", out_result, s & m);
        end

        // R10: back-to-back requests
        in_valid = 1'b1; op_sel = 1'b0;
        src_word = 64'hFFFF_0000_FFFF_0000; mask_word = 64'h00FF_00FF_00FF_00FF;
        @(negedge clk);
        check("R10 first valid", {63'd0, out_valid}, 64'd1);
        check("R10 first", out_result, ref_ext(64'hFFFF_0000_FFFF_0000, 64'h00FF_00FF_00FF_00FF));
        op_sel = 1'b1;
        src_word = 64'h0000_0000_0000_00A5; mask_word = 64'hF000_0000_0000_000F;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 second valid", {63'd0, out_valid}, 64'd1);
        check("R10 second", out_result, 64'h A000_0000_0000_0005);
        @(negedge clk);
        check("R5 valid drops", {63'd0, out_valid}, 64'd0);

        // R6: reset mid-run clears result
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 reset result", out_result, 64'd0);
        check("R6 reset valid", {63'd0, out_valid}, 64'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule